// File: doc/BRIEF.md
# Buffered Reset-Synchronous PWM Timer Pair

This block is a two-channel timer pair that produces three PWM phases, each with an inverted companion pin, from one shared up-counter. The counter starts at zero and returns to zero on the cycle after it equals the period register, which is compare register A of channel 0. The duties of the three phases come from compare register B of channel 0, compare register A of channel 1 and compare register B of channel 1. Each phase goes high when the counter returns to zero and goes low after the counter equals its duty register.

Each channel also has secondary registers C and D. Two mode bits that exist only on channel 0 decide whether these act as double buffers. With the A-buffer bit set, every channel's C register is copied into its A register. With the B-buffer bit set, every channel's D register is copied into its B register. Both copies happen in the clock cycle in which the counter returns to zero, so a new period, and new duties on every phase, begin together at the next period boundary. A register that is acting as a buffer never raises its compare-match flag. Channel 1 has only a single mode bit. It has no effect on buffering, and while it is set it holds the inverted pin of phase 1 low.

Software reaches every register through a single-cycle write port. Compare-match flags are cleared by writing ones.

Top module: `rsync_pwm_pair`

## Requirements
- R1: `cnt_o` rises by one per clock and is 0 on the cycle after it equals the period (channel 0 register A, address 0), so one period lasts period+1 clocks.
- R2: Phase p (0: ch0 B at address 1, 1: ch1 A at address 4, 2: ch1 B at address 5) is high for counter values 0..duty and low from duty+1 to the period when duty < period; when duty >= period it stays high. This holds from the second period boundary after the registers settle.
- R3: `pwm_n_o[p]` is the inverse of `pwm_o[p]` for every phase, except in the case given by R8.
- R4: With buffering off, registers C and D (addresses 2, 3, 6, 7) are plain compare registers. Flag bit 4*ch+k (k: A=0, B=1, C=2, D=3) is 1 on the cycle after the counter equals register k of channel ch.
- R5: When bit 0 of the channel-0 mode register (address 8) is 1, each channel's C register loads into its A register in the same cycle as the counter clear. Writes to C therefore change no output until the next period, and then they change the outputs of both channels together.
- R6: Bit 1 of address 8 does the same for D into B, independently of bit 0. With bit 1 at 0, a write to B acts at once and D is never loaded into B.
- R7: While bit 0 (bit 1) of address 8 is 1, the C (D) flags of both channels never become set.
- R8: Writes to the channel-1 mode register (address 9) never enable buffering. While its bit 0 is 1, `pwm_n_o[1]` is held at 0.
- R9: Writing data with bit k set to address 10 (channel 0) or address 11 (channel 1) clears flag k of that channel. If a match sets the same flag in the same cycle, the flag stays 1.
- R10: After reset the counter is 0, all flags are 0, all `pwm_o` are 0, all `pwm_n_o` are 1, and all compare registers hold all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address (0-7 compare registers, 8/9 mode, 10/11 flag clear) |
| wr_data_i | input | W | Write data |
| cnt_o | output | W | Counter value |
| flags_o | output | 8 | Compare-match flags, bit 4*ch+k |
| pwm_o | output | 3 | PWM phases |
| pwm_n_o | output | 3 | Inverted PWM phases |

## Verification
The bench sweeps every duty from 0 to period+1 over several short periods. This targets the edges at duty 0, duty equal to the period, and duty beyond the period. A design that lets the duty compare win over the counter clear, or that compares one cycle late, would show a phase that is one clock too short or too long, or that never goes high. The buffered case writes new C and D values in the middle of a period and checks that the rest of that period keeps the old duties, and that all three phases switch at the same boundary. A design that loads on the wrong edge or loads only one channel would change a phase too early or too late. The bench also drives a flag clear in the exact cycle of a match to catch a clear that wins. It checks that buffering registers raise no flags, that the channel-1 mode bits leave buffering alone, and that the channel-1 A bit holds the phase-1 inverted pin low.

// File: rtl/rsync_pwm_pkg.sv
package rsync_pwm_pkg;
  localparam int NCH  = 2;
  localparam int NREG = 4;
  localparam int NPH  = 3;
  localparam int PH_KILL = 1;  // phase whose inverted pin the ch1 mode bit blocks
  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_D = 2'd3} reg_sel_e;
  localparam logic [2:0] ADR_MODE = 3'b100;  // addr 8/9, bit0 picks channel
  localparam logic [2:0] ADR_CLR  = 3'b101;  // addr 10/11, bit0 picks channel
endpackage

// File: rtl/rsp_counter.sv
module rsp_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == prd_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/rsp_wave.sv
module rsp_wave #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_i,
  input  logic         wrap_i,
  output logic         out_o
);
  logic out_q;

  assign out_o = out_q;

  // clear point outranks the duty match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 out_q <= 1'b0;
    else if (wrap_i)             out_q <= 1'b1;
    else if (cnt_i == duty_i)    out_q <= 1'b0;
  end

  // R2
  rise_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> out_q);
  // R2
  fall_on_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && cnt_i == duty_i) |=> !out_q);
endmodule

// File: rtl/rsp_channel.sv
module rsp_channel
  import rsync_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    cnt_i,
  input  logic            wrap_i,
  input  logic            buf_a_i,
  input  logic            buf_b_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            clr_en_i,
  input  logic [NREG-1:0] clr_mask_i,
  output logic [W-1:0]    reg_a_o,
  output logic [W-1:0]    reg_b_o,
  output logic [NREG-1:0] flags_o
);
  logic [W-1:0]    regs_q [NREG];
  logic [NREG-1:0] flag_q, set_w, clr_w;

  assign reg_a_o = regs_q[SEL_A];
  assign reg_b_o = regs_q[SEL_B];
  assign flags_o = flag_q;

  // buffer transfer is placed last so it wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= '1;
    end else begin
      if (wr_en_i)            regs_q[wr_sel_i] <= wr_data_i;
      if (wrap_i && buf_a_i)  regs_q[SEL_A]    <= regs_q[SEL_C];
      if (wrap_i && buf_b_i)  regs_q[SEL_B]    <= regs_q[SEL_D];
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) set_w[k] = (cnt_i == regs_q[k]);
    set_w[SEL_C] = set_w[SEL_C] && !buf_a_i;
    set_w[SEL_D] = set_w[SEL_D] && !buf_b_i;
    clr_w = clr_en_i ? clr_mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_w | (flag_q & ~clr_w);
  end

  // R5
  a_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && buf_a_i) |=> (regs_q[SEL_A] == $past(regs_q[SEL_C])));
  // R6
  b_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && buf_b_i) |=> (regs_q[SEL_B] == $past(regs_q[SEL_D])));
  // R7
  c_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_a_i |=> !$rose(flag_q[SEL_C]));
  // R7
  d_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_b_i |=> !$rose(flag_q[SEL_D]));
  // R9
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_mask_i[SEL_B] && cnt_i == regs_q[SEL_B]) |=> flag_q[SEL_B]);
endmodule

// File: rtl/rsync_pwm_pair.sv
module rsync_pwm_pair
  import rsync_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [3:0]           wr_addr_i,
  input  logic [W-1:0]         wr_data_i,
  output logic [W-1:0]         cnt_o,
  output logic [NCH*NREG-1:0]  flags_o,
  output logic [NPH-1:0]       pwm_o,
  output logic [NPH-1:0]       pwm_n_o
);
  logic [1:0]   mode0_q;   // {buf_b, buf_a}, steers both channels
  logic         kill_q;    // ch1 A-buffer bit: only blocks one pin
  logic [W-1:0] reg_a [NCH];
  logic [W-1:0] reg_b [NCH];
  logic [W-1:0] duty  [NPH];
  logic [W-1:0] cnt;
  logic         wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode0_q <= '0;
      kill_q  <= 1'b0;
    end else if (wr_en_i && wr_addr_i[3:1] == ADR_MODE) begin
      if (wr_addr_i[0]) kill_q  <= wr_data_i[0];
      else              mode0_q <= wr_data_i[1:0];
    end
  end

  rsp_counter #(.W(W)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .prd_i(reg_a[0]), .cnt_o(cnt), .wrap_o(wrap)
  );
  assign cnt_o = cnt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en_i && !wr_addr_i[3] && (wr_addr_i[2] == 1'(ch));
    assign clr_hit = wr_en_i && (wr_addr_i[3:1] == ADR_CLR) && (wr_addr_i[0] == 1'(ch));
    rsp_channel #(.W(W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .wrap_i    (wrap),
      .buf_a_i   (mode0_q[0]),
      .buf_b_i   (mode0_q[1]),
      .wr_en_i   (wr_hit),
      .wr_sel_i  (wr_addr_i[1:0]),
      .wr_data_i (wr_data_i),
      .clr_en_i  (clr_hit),
      .clr_mask_i(wr_data_i[NREG-1:0]),
      .reg_a_o   (reg_a[ch]),
      .reg_b_o   (reg_b[ch]),
      .flags_o   (flags_o[NREG*ch +: NREG])
    );
  end

  assign duty[0] = reg_b[0];
  assign duty[1] = reg_a[1];
  assign duty[2] = reg_b[1];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    rsp_wave #(.W(W)) u_wave (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .duty_i(duty[p]),
      .wrap_i(wrap), .out_o(pwm_o[p])
    );
    if (p == PH_KILL) begin : g_kill
      assign pwm_n_o[p] = !kill_q && !pwm_o[p];
    end else begin : g_inv
      assign pwm_n_o[p] = !pwm_o[p];
    end
  end
endmodule

// File: tb/sim_rsync_pwm_pair.sv
module sim_rsync_pwm_pair;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int WDOG  = 200000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [3:0]   wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] cnt_o;
  logic [7:0]   flags_o;
  logic [2:0]   pwm_o, pwm_n_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rsync_pwm_pair #(.W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .flags_o(flags_o), .pwm_o(pwm_o),
    .pwm_n_o(pwm_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int adr, input int dat);
    wr_en_i   = 1'b1;
    wr_addr_i = 4'(adr);
    wr_data_i = W'(dat);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (int'(cnt_o) != v) @(negedge clk_i);
  endtask

  // two clear points so registers are settled for a whole period
  task automatic sync2();
    repeat (2) begin
      @(negedge clk_i);
      wait_cnt(0);
    end
  endtask

  task automatic check_pins(input string tag, input int c, input int prd,
                            input int d0, input int d1, input int d2, input bit kill);
    for (int p = 0; p < 3; p++) begin
      int dp = (p == 0) ? d0 : (p == 1) ? d1 : d2;
      int e  = ((c <= dp) || (dp >= prd)) ? 1 : 0;
      chk(tag, int'(pwm_o[p]), e);
      if (kill && p == 1) chk("R8", int'(pwm_n_o[p]), 0);
      else                chk("R3", int'(pwm_n_o[p]), 1 - e);
    end
  endtask

  task automatic check_period(input string tag, input int prd,
                              input int d0, input int d1, input int d2, input bit kill);
    for (int i = 0; i <= prd; i++) begin
      chk("R1", int'(cnt_o), i);
      check_pins(tag, i, prd, d0, d1, d2, kill);
      @(negedge clk_i);
    end
    chk("R1", int'(cnt_o), 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    n_bad++;
    $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    chk("R10", int'(cnt_o), 0);
    chk("R10", int'(flags_o), 0);
    chk("R10", int'(pwm_o), 0);
    chk("R10", int'(pwm_n_o), 7);
    @(negedge clk_i);
    chk("R10", int'(cnt_o), 1);

    // R1 R2 R3: duty sweep, unbuffered
    for (int prd = 3; prd <= 7; prd += 2) begin
      for (int d = 0; d <= prd + 1; d++) begin
        int d1 = (d + 1) % (prd + 2);
        int d2 = prd + 1 - d;
        wr(0, prd); wr(1, d); wr(4, d1); wr(5, d2);
        sync2();
        check_period("R2", prd, d, d1, d2, 1'b0);
      end
    end

    // R4 R9: ordinary compare on C/D, flag clear and set priority (prd = 7)
    wr(2, 2); wr(7, 1);
    sync2();
    wait_cnt(4);
    wr(10, 4);
    chk("R4", int'(flags_o[2]), 0);
    wr(11, 8);
    chk("R4", int'(flags_o[7]), 0);
    wait_cnt(3);
    chk("R4", int'(flags_o[2]), 1);
    chk("R4", int'(flags_o[7]), 1);
    wr(10, 4);
    chk("R9", int'(flags_o[2]), 0);
    wait_cnt(2);
    wr(10, 4);  // clear lands on the matching edge
    chk("R9", int'(flags_o[2]), 1);

    // R7: buffering on both, C/D flags stay low
    wr(2, 7); wr(3, 2); wr(6, 3); wr(7, 1);
    wr(8, 3);
    wr(10, 15); wr(11, 15);
    sync2();
    chk("R7", int'(flags_o[2]), 0);
    chk("R7", int'(flags_o[3]), 0);
    chk("R7", int'(flags_o[6]), 0);
    chk("R7", int'(flags_o[7]), 0);
    chk("R7", int'(flags_o[1]), 1);
    chk("R7", int'(flags_o[4]), 1);

    // R5: new C/D mid-period take effect together at the next period
    check_period("R5", 7, 2, 3, 1, 1'b0);
    @(negedge clk_i);
    wr(3, 5); wr(6, 6); wr(7, 4);
    for (int c = 4; c <= 7; c++) begin
      chk("R1", int'(cnt_o), c);
      check_pins("R5", c, 7, 2, 3, 1, 1'b0);
      @(negedge clk_i);
    end
    check_period("R5", 7, 5, 6, 4, 1'b0);

    // R6: B unbuffered while A stays buffered; D is not loaded, B acts at once
    wr(8, 1);
    wr(7, 0);
    wr(5, 6);
    for (int c = 3; c <= 7; c++) begin
      chk("R1", int'(cnt_o), c);
      check_pins("R6", c, 7, 5, 6, 6, 1'b0);
      @(negedge clk_i);
    end
    check_period("R6", 7, 5, 6, 6, 1'b0);

    // R8: ch1 mode bits never buffer, bit 0 blocks pwm_n_o[1]
    wr(8, 0);
    wr(9, 3);
    wr(6, 1);
    sync2();
    check_period("R8", 7, 5, 6, 6, 1'b1);
    wr(9, 0);
    sync2();
    check_period("R3", 7, 5, 6, 6, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule